// File: doc/BRIEF.md
# Architected Compare Timer

This block gives one processor core a free-running 64-bit system counter and two compare timers that watch it: a physical instance and a virtual instance. The virtual instance sees the same count as the physical one, because no offset is applied. Each timer holds a 64-bit compare value and a small control word. It also offers a signed 32-bit countdown view of that same compare value, so software can either program an absolute deadline or ask for an interrupt a relative number of ticks from now. Each timer drives a level-sensitive interrupt line.

Software reaches the registers through a single-cycle request port. The port carries a register select, an instance select, a privilege flag and 64-bit write data. Read data comes back in the same cycle. A kernel-control register decides which reads unprivileged code may make. Every other unprivileged read returns zero and raises an undefined-access flag. A frequency register reports the tick rate to software and does not change it. The counter advances on a tick strobe that the surrounding logic derives from the core clock: one tick per 16 ns gives 62.5 MHz.

Top module: `arch_timer_core`

## Requirements
- R1: The 64-bit counter resets to 0 and rises by exactly one at every clock edge where `tick_en` is high; otherwise it holds. Select 5 reads it for either instance, and both instances return the same value.
- R2: Select 2 is the control word: bit 0 enable, bit 1 mask, bit 2 a read-only status. A write stores only bits 1:0. Both control words reset to 0.
- R3: While enabled, status is 1 exactly when counter >= compare value, compared as unsigned 64-bit numbers. Status is registered, so it reflects the counter, compare and control values of the previous cycle.
- R4: Interrupt output `timer_irq[i]` (bit 0 physical, bit 1 virtual) equals status AND NOT mask, registered like status. Changing only the mask changes the output one cycle after the write.
- R5: While enable is 0, status reads 0 and the interrupt stays low, whatever the compare result.
- R6: Select 3 reads the low 32 bits of (compare value minus current counter), zero-extended to 64 bits.
- R7: A write to select 3 sets the compare value to the current counter plus write data bits 31:0 sign-extended to 64 bits. The new compare value is visible on the next cycle.
- R8: Select 4 is the 64-bit compare value. It resets to 0 and reads back what was written.
- R9: Select 0 is the frequency word. It resets to 62,500,000 and reads back the low 32 bits written, and a write does not change the tick rate.
- R10: An unprivileged read is allowed only as follows. Kernel-control bit 0 opens the counter of instance 0, and bit 1 opens the counter of instance 1. Bit 9 opens the control, countdown and compare registers of instance 0, and bit 8 opens those of instance 1. Bit 0 or bit 1 opens the frequency word. Every other unprivileged read returns 0 with `rsp_undef` high, and privileged reads never raise it.
- R11: Select 1 is the 10-bit kernel-control register and resets to 0. Writes to any register take effect only when `req_priv` is high; unprivileged writes change nothing.
- R12: Selects 6 and 7 are unassigned: a privileged read returns 0, and an unprivileged read raises `rsp_undef`. A read of select 1 by unprivileged code always raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Counter advance strobe, one per 16 ns of reference time |
| req_valid | input | 1 | Register access strobe, one cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | 3 | Register select (0 freq, 1 kernel ctrl, 2 ctrl, 3 countdown, 4 compare, 5 counter) |
| req_inst | input | 1 | Timer instance: 0 physical, 1 virtual |
| req_priv | input | 1 | 1 = privileged requester |
| req_wdata | input | 64 | Write data |
| rsp_rdata | output | 64 | Read data, same cycle as the request |
| rsp_undef | output | 1 | Unprivileged read not permitted |
| timer_irq | output | 2 | Level interrupts, bit 0 physical, bit 1 virtual |

## Verification
Read data and the undefined-access flag depend on the request in the same cycle. The bench therefore drives each request just after a falling edge and samples the response one time step later, before the next rising edge. A register write becomes visible to a read in the cycle after the rising edge that takes it. Status and the interrupt lag any change of counter, compare value or control by exactly one edge. The bench's reference model holds its state per edge: it computes the next status from the values before the edge, then applies the write and the tick. It compares `timer_irq` against that model at every falling edge, so a result that arrives one cycle early or late shows up as a miscompare.

// File: rtl/arch_timer_pkg.sv
package arch_timer_pkg;

  localparam int unsigned CNT_W      = 64;
  localparam int unsigned TV_W       = 32;
  localparam int unsigned FREQ_W     = 32;
  localparam int unsigned KCTL_W     = 10;
  localparam int unsigned NUM_TIMERS = 2;

  // Control word bit positions (software visible)
  localparam int unsigned CTL_EN   = 0;
  localparam int unsigned CTL_MASK = 1;
  localparam int unsigned CTL_STAT = 2;

  // Kernel-control permission bits
  localparam int unsigned KC_CNT0 = 0;
  localparam int unsigned KC_CNT1 = 1;
  localparam int unsigned KC_TMR1 = 8;
  localparam int unsigned KC_TMR0 = 9;

  typedef enum logic [2:0] {
    SEL_FREQ  = 3'd0,
    SEL_KCTL  = 3'd1,
    SEL_CTRL  = 3'd2,
    SEL_TVAL  = 3'd3,
    SEL_CVAL  = 3'd4,
    SEL_COUNT = 3'd5
  } regsel_e;

  // Signed countdown view of a compare value
  function automatic logic [TV_W-1:0] tval_view(input logic [CNT_W-1:0] cmp,
                                                input logic [CNT_W-1:0] cnt);
    logic [CNT_W-1:0] diff;
    diff = cmp - cnt;
    return diff[TV_W-1:0];
  endfunction

  // Compare value produced by a countdown write
  function automatic logic [CNT_W-1:0] tval_target(input logic [CNT_W-1:0] cnt,
                                                   input logic [TV_W-1:0]  delta);
    logic [CNT_W-1:0] ext;
    ext = {{(CNT_W-TV_W){delta[TV_W-1]}}, delta};
    return cnt + ext;
  endfunction

  // Level status of one timer
  function automatic logic status_level(input logic             en,
                                        input logic [CNT_W-1:0] cnt,
                                        input logic [CNT_W-1:0] cmp);
    return en && (cnt >= cmp);
  endfunction

  // Unprivileged read permission
  function automatic logic read_permitted(input logic [2:0]        sel,
                                          input logic              inst,
                                          input logic [KCTL_W-1:0] kc);
    logic tmr_ok;
    tmr_ok = inst ? kc[KC_TMR1] : kc[KC_TMR0];
    case (sel)
      SEL_FREQ:  return kc[KC_CNT0] | kc[KC_CNT1];
      SEL_CTRL,
      SEL_TVAL,
      SEL_CVAL:  return tmr_ok;
      SEL_COUNT: return inst ? kc[KC_CNT1] : kc[KC_CNT0];
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/at_syscount.sv
module at_syscount
  import arch_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  output logic [CNT_W-1:0] count
);

  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (tick_en) begin
      count_q <= count_q + {{(CNT_W-1){1'b0}}, 1'b1};
    end
  end

  assign count = count_q;

endmodule

// File: rtl/at_timer_inst.sv
module at_timer_inst
  import arch_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count,
  input  logic             ctl_we,
  input  logic             cval_we,
  input  logic             tval_we,
  input  logic [CNT_W-1:0] wdata,
  output logic             en,
  output logic             mask,
  output logic             istatus,
  output logic             irq,
  output logic [CNT_W-1:0] cval,
  output logic [TV_W-1:0]  tval
);

  logic             en_q;
  logic             mask_q;
  logic             ist_q;
  logic             irq_q;
  logic [CNT_W-1:0] cval_q;
  logic             hit_now;

  assign hit_now = status_level(en_q, count, cval_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mask_q <= 1'b0;
      cval_q <= '0;
      ist_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (ctl_we) begin
        en_q   <= wdata[CTL_EN];
        mask_q <= wdata[CTL_MASK];
      end
      if (cval_we) begin
        cval_q <= wdata;
      end else if (tval_we) begin
        cval_q <= tval_target(count, wdata[TV_W-1:0]);
      end
      ist_q <= hit_now;
      irq_q <= hit_now & ~mask_q;
    end
  end

  assign en      = en_q;
  assign mask    = mask_q;
  assign istatus = ist_q;
  assign irq     = irq_q;
  assign cval    = cval_q;
  assign tval    = tval_view(cval_q, count);

endmodule

// File: rtl/at_access.sv
module at_access
  import arch_timer_pkg::*;
#(
  parameter logic [FREQ_W-1:0] FREQ_RESET = 32'd62_500_000
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 req_valid,
  input  logic                                 req_write,
  input  logic [2:0]                           req_sel,
  input  logic                                 req_inst,
  input  logic                                 req_priv,
  input  logic [FREQ_W-1:0]                    wr_low,
  input  logic [CNT_W-1:0]                     count,
  input  logic [NUM_TIMERS-1:0]                t_en,
  input  logic [NUM_TIMERS-1:0]                t_mask,
  input  logic [NUM_TIMERS-1:0]                t_ist,
  input  logic [NUM_TIMERS-1:0][CNT_W-1:0]     t_cval,
  input  logic [NUM_TIMERS-1:0][TV_W-1:0]      t_tval,
  output logic [NUM_TIMERS-1:0]                ctl_we,
  output logic [NUM_TIMERS-1:0]                cval_we,
  output logic [NUM_TIMERS-1:0]                tval_we,
  output logic [KCTL_W-1:0]                    kctl,
  output logic [CNT_W-1:0]                     rdata,
  output logic                                 undef
);

  logic [KCTL_W-1:0] kctl_q;
  logic [FREQ_W-1:0] freq_q;
  logic              wr_ok;
  logic              rd_req;
  logic              rd_allow;
  logic [CNT_W-1:0]  rd_mux;

  assign wr_ok = req_valid & req_write & req_priv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kctl_q <= '0;
      freq_q <= FREQ_RESET;
    end else if (wr_ok) begin
      if (req_sel == SEL_KCTL) kctl_q <= wr_low[KCTL_W-1:0];
      if (req_sel == SEL_FREQ) freq_q <= wr_low;
    end
  end

  for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_we
    logic hit_inst;
    assign hit_inst   = wr_ok && (req_inst == g[0]);
    assign ctl_we[g]  = hit_inst && (req_sel == SEL_CTRL);
    assign cval_we[g] = hit_inst && (req_sel == SEL_CVAL);
    assign tval_we[g] = hit_inst && (req_sel == SEL_TVAL);
  end

  always_comb begin
    case (req_sel)
      SEL_FREQ:  rd_mux = {{(CNT_W-FREQ_W){1'b0}}, freq_q};
      SEL_KCTL:  rd_mux = {{(CNT_W-KCTL_W){1'b0}}, kctl_q};
      SEL_CTRL:  rd_mux = {{(CNT_W-3){1'b0}}, t_ist[req_inst],
                          t_mask[req_inst], t_en[req_inst]};
      SEL_TVAL:  rd_mux = {{(CNT_W-TV_W){1'b0}}, t_tval[req_inst]};
      SEL_CVAL:  rd_mux = t_cval[req_inst];
      SEL_COUNT: rd_mux = count;
      default:   rd_mux = '0;
    endcase
  end

  assign rd_req   = req_valid & ~req_write;
  assign rd_allow = req_priv | read_permitted(req_sel, req_inst, kctl_q);
  assign undef    = rd_req & ~rd_allow;
  assign rdata    = (rd_req & rd_allow) ? rd_mux : '0;
  assign kctl     = kctl_q;

endmodule

// File: rtl/arch_timer_core.sv
module arch_timer_core
  import arch_timer_pkg::*;
#(
  parameter logic [FREQ_W-1:0] FREQ_RESET = 32'd62_500_000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick_en,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [2:0]            req_sel,
  input  logic                  req_inst,
  input  logic                  req_priv,
  input  logic [CNT_W-1:0]      req_wdata,
  output logic [CNT_W-1:0]      rsp_rdata,
  output logic                  rsp_undef,
  output logic [NUM_TIMERS-1:0] timer_irq
);

  logic [CNT_W-1:0]                 count_q;
  logic [NUM_TIMERS-1:0]            t_en;
  logic [NUM_TIMERS-1:0]            t_mask;
  logic [NUM_TIMERS-1:0]            t_ist;
  logic [NUM_TIMERS-1:0]            t_irq;
  logic [NUM_TIMERS-1:0][CNT_W-1:0] t_cval;
  logic [NUM_TIMERS-1:0][TV_W-1:0]  t_tval;
  logic [NUM_TIMERS-1:0]            ctl_we;
  logic [NUM_TIMERS-1:0]            cval_we;
  logic [NUM_TIMERS-1:0]            tval_we;
  logic [KCTL_W-1:0]                kctl_q;

  at_syscount u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .count   (count_q)
  );

  for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_tmr
    at_timer_inst u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .count   (count_q),
      .ctl_we  (ctl_we[g]),
      .cval_we (cval_we[g]),
      .tval_we (tval_we[g]),
      .wdata   (req_wdata),
      .en      (t_en[g]),
      .mask    (t_mask[g]),
      .istatus (t_ist[g]),
      .irq     (t_irq[g]),
      .cval    (t_cval[g]),
      .tval    (t_tval[g])
    );
  end

  at_access #(.FREQ_RESET(FREQ_RESET)) u_access (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_sel   (req_sel),
    .req_inst  (req_inst),
    .req_priv  (req_priv),
    .wr_low    (req_wdata[FREQ_W-1:0]),
    .count     (count_q),
    .t_en      (t_en),
    .t_mask    (t_mask),
    .t_ist     (t_ist),
    .t_cval    (t_cval),
    .t_tval    (t_tval),
    .ctl_we    (ctl_we),
    .cval_we   (cval_we),
    .tval_we   (tval_we),
    .kctl      (kctl_q),
    .rdata     (rsp_rdata),
    .undef     (rsp_undef)
  );

  assign timer_irq = t_irq;

endmodule

// File: rtl/at_checker.sv
module at_checker
  import arch_timer_pkg::*;
(
  input logic                            clk,
  input logic                            rst_n,
  input logic                            tick_en,
  input logic                            req_valid,
  input logic                            req_write,
  input logic                            req_priv,
  input logic                            rsp_undef,
  input logic [CNT_W-1:0]                count,
  input logic [NUM_TIMERS-1:0]           en,
  input logic [NUM_TIMERS-1:0]           mask,
  input logic [NUM_TIMERS-1:0]           ist,
  input logic [NUM_TIMERS-1:0]           irq,
  input logic [NUM_TIMERS-1:0][CNT_W-1:0] cval,
  input logic [KCTL_W-1:0]               kctl
);

  a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en |=> (count == $past(count) + 64'd1));

  a_r1_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(count));

  a_r10_undef_unpriv: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_undef |-> (req_valid && !req_write && !req_priv));

  a_r11_kctl_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !req_priv) |=> $stable(kctl));

  for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_chk
    a_r3_level: assert property (@(posedge clk) disable iff (!rst_n)
      ist[g] == $past(en[g] && (count >= cval[g])));

    a_r4_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
      irq[g] |-> (ist[g] && !$past(mask[g])));

    a_r5_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(en[g]) |-> (!ist[g] && !irq[g]));
  end

endmodule

bind arch_timer_core at_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_en   (tick_en),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_priv  (req_priv),
  .rsp_undef (rsp_undef),
  .count     (count_q),
  .en        (t_en),
  .mask      (t_mask),
  .ist       (t_ist),
  .irq       (timer_irq),
  .cval      (t_cval),
  .kctl      (kctl_q)
);

// File: tb/arch_timer_core_bench.sv
module arch_timer_core_bench;

  localparam logic [2:0] S_FREQ = 3'd0, S_KCTL = 3'd1, S_CTRL = 3'd2,
                         S_TVAL = 3'd3, S_CVAL = 3'd4, S_CNT  = 3'd5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [2:0]  req_sel = 3'd0;
  logic        req_inst = 1'b0;
  logic        req_priv = 1'b0;
  logic [63:0] req_wdata = 64'd0;
  logic [63:0] rsp_rdata;
  logic        rsp_undef;
  logic [1:0]  timer_irq;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  always #5 clk = ~clk;

  arch_timer_core u_arch_timer_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_sel   (req_sel),
    .req_inst  (req_inst),
    .req_priv  (req_priv),
    .req_wdata (req_wdata),
    .rsp_rdata (rsp_rdata),
    .rsp_undef (rsp_undef),
    .timer_irq (timer_irq)
  );

  // ---------------- behavioural reference model ----------------
  logic [63:0] m_cnt;
  logic [63:0] m_cval [2];
  bit          m_en   [2];
  bit          m_mask [2];
  bit          m_ist  [2];
  bit          m_irq  [2];
  logic [9:0]  m_kctl;
  logic [31:0] m_freq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_kctl = 0; m_freq = 32'd62500000;
      for (int i = 0; i < 2; i++) begin
        m_cval[i] = 0; m_en[i] = 0; m_mask[i] = 0; m_ist[i] = 0; m_irq[i] = 0;
      end
    end else begin
      for (int i = 0; i < 2; i++) begin
        m_ist[i] = m_en[i] && (m_cnt >= m_cval[i]);
        m_irq[i] = m_ist[i] && !m_mask[i];
      end
      if (req_valid && req_write && req_priv) begin
        case (req_sel)
          S_FREQ: m_freq = req_wdata[31:0];
          S_KCTL: m_kctl = req_wdata[9:0];
          S_CTRL: begin m_en[req_inst] = req_wdata[0]; m_mask[req_inst] = req_wdata[1]; end
          S_TVAL: m_cval[req_inst] = m_cnt + 64'(signed'(req_wdata[31:0]));
          S_CVAL: m_cval[req_inst] = req_wdata;
          default: ;
        endcase
      end
      if (tick_en) m_cnt = m_cnt + 1;
    end
  end

  task automatic expect_read(input logic [2:0] s, input bit i, input bit p,
                             output logic [63:0] d, output logic u);
    bit ok;
    logic [63:0] v;
    bit tmr;
    logic [63:0] diff;
    tmr = i ? m_kctl[8] : m_kctl[9];
    diff = m_cval[i] - m_cnt;
    case (s)
      S_FREQ: begin ok = m_kctl[0] | m_kctl[1]; v = {32'd0, m_freq}; end
      S_KCTL: begin ok = 0; v = {54'd0, m_kctl}; end
      S_CTRL: begin ok = tmr; v = {61'd0, m_ist[i], m_mask[i], m_en[i]}; end
      S_TVAL: begin ok = tmr; v = {32'd0, diff[31:0]}; end
      S_CVAL: begin ok = tmr; v = m_cval[i]; end
      S_CNT:  begin ok = m_kctl[i]; v = m_cnt; end
      default: begin ok = 0; v = 0; end
    endcase
    if (!p && !ok) begin d = 0; u = 1; end
    else begin d = v; u = 0; end
  endtask

  // Interrupt lines compared against the model on every falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      vectors++;
      if (timer_irq !== {m_irq[1], m_irq[0]}) begin
        fails++;
        $display("FAIL R3/R4/R5 irq: got %b expected %b", timer_irq, {m_irq[1], m_irq[0]});
      end
    end
  end

  task automatic op(input bit w, input logic [2:0] s, input bit i, input bit p,
                    input logic [63:0] d, input string tag);
    logic [63:0] ed;
    logic eu;
    @(negedge clk);
    req_valid = 1; req_write = w; req_sel = s; req_inst = i; req_priv = p; req_wdata = d;
    if (!w) begin
      #1;
      expect_read(s, i, p, ed, eu);
      vectors++;
      if (rsp_rdata !== ed || rsp_undef !== eu) begin
        fails++;
        $display("FAIL %s sel=%0d inst=%0d priv=%0b: got data=%h undef=%b, expected data=%h undef=%b",
                 tag, s, i, p, rsp_rdata, rsp_undef, ed, eu);
      end
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    req_valid = 0; req_write = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic set_tick(input bit t);
    @(negedge clk);
    tick_en = t;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;

    // reset state
    op(0, S_FREQ, 0, 1, 0, "R9 freq reset");
    op(0, S_KCTL, 0, 1, 0, "R11 kctl reset");
    op(0, S_CTRL, 0, 1, 0, "R2 ctrl reset");
    op(0, S_CTRL, 1, 1, 0, "R2 ctrl reset");
    op(0, S_CVAL, 0, 1, 0, "R8 cval reset");
    op(0, S_CNT,  0, 1, 0, "R1 count reset");
    op(0, S_TVAL, 1, 1, 0, "R6 tval reset");

    // counter runs, both views equal
    set_tick(1);
    idle(5);
    op(0, S_CNT, 0, 1, 0, "R1 count phys");
    op(0, S_CNT, 1, 1, 0, "R1 count virt");

    // physical compare fires
    op(1, S_CVAL, 0, 1, m_cnt + 64'd10, "R8");
    op(0, S_CVAL, 0, 1, 0, "R8 cval readback");
    op(1, S_CTRL, 0, 1, 64'd1, "R3");
    idle(15);
    op(0, S_CTRL, 0, 1, 0, "R3 status set");
    // mask toggling
    op(1, S_CTRL, 0, 1, 64'd3, "R4");
    op(0, S_CTRL, 0, 1, 0, "R4 masked ctrl");
    idle(2);
    op(1, S_CTRL, 0, 1, 64'd1, "R4");
    idle(2);
    // only bits 1:0 stored
    op(1, S_CTRL, 0, 1, 64'hFF, "R2");
    op(0, S_CTRL, 0, 1, 0, "R2 write mask");
    // disable clears status and irq
    op(1, S_CTRL, 0, 1, 64'd0, "R5");
    idle(2);
    op(0, S_CTRL, 0, 1, 0, "R5 disabled status");

    // virtual: negative countdown write fires at once
    op(1, S_CTRL, 1, 1, 64'd1, "R7");
    op(1, S_TVAL, 1, 1, 64'hFFFF_FFFB, "R7 negative");
    op(0, S_CVAL, 1, 1, 0, "R7 cval from tval");
    op(0, S_TVAL, 1, 1, 0, "R6 tval negative");
    idle(2);
    op(1, S_TVAL, 1, 1, 64'd20, "R7 positive");
    op(0, S_TVAL, 1, 1, 0, "R6 tval countdown");
    op(0, S_TVAL, 1, 1, 0, "R6 tval countdown");
    idle(25);
    op(0, S_TVAL, 1, 1, 0, "R6 tval past deadline");
    // unsigned compare: far deadline never fires
    op(1, S_CVAL, 1, 1, 64'hFFFF_FFFF_FFFF_FFFF, "R3 unsigned");
    idle(3);
    op(0, S_CTRL, 1, 1, 0, "R3 unsigned compare");

    // frequency word
    op(1, S_FREQ, 0, 1, 64'hABCD_0000_0000_1000, "R9");
    op(0, S_FREQ, 0, 1, 0, "R9 freq readback");
    idle(3);
    op(0, S_CNT, 0, 1, 0, "R9 tick rate unchanged");

    // counter holds without tick
    set_tick(0);
    idle(3);
    op(0, S_CNT, 1, 1, 0, "R1 count hold");
    set_tick(1);

    // permissions
    for (int s = 0; s < 8; s++)
      for (int i = 0; i < 2; i++)
        op(0, 3'(s), i[0], 0, 0, "R10 R12 unpriv kctl=0");
    foreach (m_kctl[b]) begin
      op(1, S_KCTL, 0, 1, 64'd1 << b, "R10");
      for (int s = 0; s < 8; s++)
        for (int i = 0; i < 2; i++)
          op(0, 3'(s), i[0], 0, 0, "R10 unpriv read");
    end
    op(0, 3'd6, 0, 1, 0, "R12 reserved priv");
    op(0, 3'd7, 1, 1, 0, "R12 reserved priv");

    // unprivileged writes ignored
    op(1, S_KCTL, 0, 0, 64'h3FF, "R11");
    op(0, S_KCTL, 0, 1, 0, "R11 kctl unchanged");
    op(1, S_CVAL, 0, 0, 64'h1234, "R11");
    op(0, S_CVAL, 0, 1, 0, "R11 cval unchanged");
    op(1, S_CTRL, 1, 0, 64'h2, "R11");
    op(0, S_CTRL, 1, 1, 0, "R11 ctrl unchanged");

    // random mix
    for (int k = 0; k < 1500; k++) begin
      logic [2:0] s;
      bit i, p, w;
      logic [63:0] d;
      s = 3'($urandom % 8);
      i = 1'($urandom % 2);
      p = ($urandom % 4) != 0;
      w = ($urandom % 3) == 0;
      d = {$urandom, $urandom};
      if (s == S_CVAL && ($urandom % 2)) d = m_cnt + 64'($urandom % 40) - 64'd20;
      if (s == S_TVAL) d = 64'($signed(32'($urandom % 60) - 32'd30));
      if (s == S_KCTL && w) d = ($urandom % 2) ? 64'h0 : d;
      tick_en = ($urandom % 4) != 0;
      op(w, s, i, p, d, "R1 R2 R3 R6 R7 R8 R9 R10 R11 R12 random");
    end

    idle(3);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: run did not complete, got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule